// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the coherence engine that sits beside the memory of one home node in a distributed shared-memory machine. For every memory block it owns it keeps a directory entry made of one presence bit per node, a dirty flag, a per-block protocol state and the identity of the node whose transaction is open. Requests arrive one per cycle as messages from other nodes. Each request is resolved in the cycle it is accepted, and the reply message is registered and presented on the following cycle.

A clean read returns the memory word and records the reader as a sharer. A read of a dirty block returns the owner's node number instead of data. The block then waits until the owner sends a write-back, which refreshes memory and leaves both nodes as sharers. An exclusive read of a clean block returns the data together with the set of other sharers, so that the requester can invalidate them. An exclusive read of a dirty block returns the current owner. In both exclusive cases the requester becomes the sole, dirty holder, and the block waits for a completion message from that requester. While a block waits, every other message aimed at it is refused with a negative acknowledgement, and the sender retries later. This keeps operations on one location serialized.

Per-block states: `BLK_IDLE` (no open transaction), `BLK_WAIT_REV` (a reader was sent to the owner and the write-back is awaited), `BLK_WAIT_DONE` (an exclusive grant was issued and the completion is awaited). Transitions: IDLE→WAIT_REV on a read of a dirty block; IDLE→WAIT_DONE on any exclusive read; WAIT_REV→IDLE on a write-back from the recorded owner; WAIT_DONE→IDLE on a completion from the recorded requester; IDLE→IDLE on a clean read; every other message leaves the state where it is.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is idle, clean and without sharers, memory word b holds INIT_BASE + b, `rsp_valid` is 0 and `req_ready` is 1 from the first cycle after reset is released.
- R2: A read (request opcode 0) of a clean idle block produces, on the cycle after acceptance, a reply with opcode DATA (0), `rsp_dest` equal to the requester, the memory word in `rsp_data`, zero in `rsp_vec`, and it adds the requester to the sharers; the block stays idle.
- R3: A read of a dirty idle block produces a reply with opcode OWNER (1) and the owning node in `rsp_owner`, and puts the block in the write-back wait state.
- R4: In the write-back wait state, a revision (opcode 2) from the recorded owner writes `req_data` to memory, clears the dirty flag, leaves the owner and the waiting reader as sharers, returns the block to idle and produces no reply.
- R5: An exclusive read (opcode 1) of a clean idle block produces a DATA reply whose `rsp_vec` is the sharer set without the requester; afterwards the requester is the only holder and the block is dirty.
- R6: An exclusive read of a dirty idle block produces an OWNER reply naming the previous owner; afterwards the requester is the only, dirty holder.
- R7: While a block waits (either wait state), any message other than the one that closes it, including a revision or completion from the wrong node, receives a NACK (reply opcode 2) and changes neither memory nor directory.
- R8: In the completion wait state, a completion (opcode 3) from the recorded requester returns the block to idle with no reply.
- R9: A revision or completion aimed at an idle block receives a NACK and changes neither memory nor directory.
- R10: Requests may be accepted on consecutive cycles; each reply appears exactly one cycle after its request, in order, and a waiting block does not hold up requests to other blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_op | input | 2 | 0 read, 1 exclusive read, 2 revision, 3 completion |
| req_node | input | NODE_W (4) | Sending node |
| req_blk | input | BLK_W (6) | Block index |
| req_data | input | DATA_W (32) | Write-back data carried by a revision |
| rsp_valid | output | 1 | Reply message present (one cycle) |
| rsp_op | output | 2 | 0 DATA, 1 OWNER, 2 NACK |
| rsp_dest | output | NODE_W (4) | Node the reply goes to |
| rsp_blk | output | BLK_W (6) | Block the reply concerns |
| rsp_data | output | DATA_W (32) | Memory word for DATA replies |
| rsp_vec | output | NODES (16) | Sharers to invalidate on an exclusive DATA reply |
| rsp_owner | output | NODE_W (4) | Owner node for OWNER replies |

## Verification
A single block is walked through its whole life: several readers build up a sharer set, an exclusive read shows that set as the invalidation vector, a reader then meets the dirty block and gets the owner, and a write-back makes fresh data readable. This separates the clean and dirty paths and shows whether sharers are kept or dropped. Wrong-node write-backs and completions, and stray closing messages to idle blocks, are each followed by a read whose reply would reveal any lost state. Back-to-back requests to two blocks, with a third block held open, show the one-cycle reply latency and the independence of blocks.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_READEX = 2'd1,
        OP_REVISE = 2'd2,
        OP_DONE   = 2'd3
    } req_op_t;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_OWNER = 2'd1,
        RSP_NACK  = 2'd2
    } rsp_op_t;

    typedef enum logic [1:0] {
        BLK_IDLE      = 2'd0,
        BLK_WAIT_REV  = 2'd1,
        BLK_WAIT_DONE = 2'd2
    } blk_state_t;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
    import dir_pkg::*;
#(
    parameter int NODES     = 16,
    parameter int BLOCKS    = 64,
    parameter int DATA_W    = 32,
    parameter int NODE_W    = $clog2(NODES),
    parameter int BLK_W     = $clog2(BLOCKS),
    parameter logic [DATA_W-1:0] INIT_BASE = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  idx,
    output blk_state_t        cur_state,
    output logic              cur_dirty,
    output logic [NODES-1:0]  cur_pres,
    output logic [NODE_W-1:0] cur_pend,
    output logic [DATA_W-1:0] cur_data,
    input  logic              wr_en,
    input  blk_state_t        wr_state,
    input  logic              wr_dirty,
    input  logic [NODES-1:0]  wr_pres,
    input  logic [NODE_W-1:0] wr_pend,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);

    blk_state_t        state_q [BLOCKS];
    logic              dirty_q [BLOCKS];
    logic [NODES-1:0]  pres_q  [BLOCKS];
    logic [NODE_W-1:0] pend_q  [BLOCKS];
    logic [DATA_W-1:0] mem_q   [BLOCKS];

    assign cur_state = state_q[idx];
    assign cur_dirty = dirty_q[idx];
    assign cur_pres  = pres_q[idx];
    assign cur_pend  = pend_q[idx];
    assign cur_data  = mem_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                state_q[b] <= BLK_IDLE;
                dirty_q[b] <= 1'b0;
                pres_q[b]  <= '0;
                pend_q[b]  <= '0;
                mem_q[b]   <= INIT_BASE + DATA_W'(b);
            end
        end else begin
            if (wr_en) begin
                state_q[idx] <= wr_state;
                dirty_q[idx] <= wr_dirty;
                pres_q[idx]  <= wr_pres;
                pend_q[idx]  <= wr_pend;
            end
            if (mem_we) begin
                mem_q[idx] <= mem_wdata;
            end
        end
    end

    // R1/R3: a dirty entry is held by exactly one node
    assert_dirty_single_holder_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dirty) |-> $onehot(wr_pres));

    // R7: an open transaction may only be closed, never re-targeted
    assert_busy_only_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cur_state != BLK_IDLE) |-> (wr_state == BLK_IDLE));

    // R5: an exclusive grant leaves a dirty block with one holder
    assert_excl_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == BLK_WAIT_DONE) |-> (wr_dirty && $countones(wr_pres) == 1));

    // R4: memory is written only while a write-back is awaited
    assert_mem_write_when_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cur_state == BLK_WAIT_REV));

endmodule

// File: rtl/dir_txn_fsm.sv
module dir_txn_fsm
    import dir_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int DATA_W = 32,
    parameter int NODE_W = $clog2(NODES)
) (
    input  logic              fire,
    input  logic [1:0]        req_op,
    input  logic [NODE_W-1:0] req_node,
    input  logic [DATA_W-1:0] req_data,
    input  blk_state_t        cur_state,
    input  logic              cur_dirty,
    input  logic [NODES-1:0]  cur_pres,
    input  logic [NODE_W-1:0] cur_pend,
    input  logic [DATA_W-1:0] cur_data,
    output logic              wr_en,
    output blk_state_t        wr_state,
    output logic              wr_dirty,
    output logic [NODES-1:0]  wr_pres,
    output logic [NODE_W-1:0] wr_pend,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              nxt_valid,
    output rsp_op_t           nxt_op,
    output logic [DATA_W-1:0] nxt_data,
    output logic [NODES-1:0]  nxt_vec,
    output logic [NODE_W-1:0] nxt_owner
);

    localparam logic [NODES-1:0] ONE_HOT0 = {{(NODES-1){1'b0}}, 1'b1};

    req_op_t           op;
    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  pend_bit;
    logic [NODE_W-1:0] owner_id;

    assign op       = req_op_t'(req_op);
    assign req_bit  = ONE_HOT0 << req_node;
    assign pend_bit = ONE_HOT0 << cur_pend;

    // owner of a dirty block is the single node whose presence bit is set
    always_comb begin
        owner_id = '0;
        for (int n = NODES - 1; n >= 0; n--) begin
            if (cur_pres[n]) owner_id = NODE_W'(n);
        end
    end

    always_comb begin
        wr_en     = 1'b0;
        wr_state  = cur_state;
        wr_dirty  = cur_dirty;
        wr_pres   = cur_pres;
        wr_pend   = cur_pend;
        mem_we    = 1'b0;
        mem_wdata = req_data;
        nxt_valid = fire;
        nxt_op    = RSP_NACK;
        nxt_data  = '0;
        nxt_vec   = '0;
        nxt_owner = '0;
        if (fire) begin
            unique case (cur_state)
                BLK_IDLE: begin
                    unique case (op)
                        OP_READ: begin
                            wr_en = 1'b1;
                            if (cur_dirty) begin
                                nxt_op    = RSP_OWNER;
                                nxt_owner = owner_id;
                                wr_state  = BLK_WAIT_REV;
                                wr_pend   = req_node;
                            end else begin
                                nxt_op   = RSP_DATA;
                                nxt_data = cur_data;
                                wr_pres  = cur_pres | req_bit;
                            end
                        end
                        OP_READEX: begin
                            wr_en = 1'b1;
                            if (cur_dirty) begin
                                nxt_op    = RSP_OWNER;
                                nxt_owner = owner_id;
                            end else begin
                                nxt_op   = RSP_DATA;
                                nxt_data = cur_data;
                                nxt_vec  = cur_pres & ~req_bit;
                            end
                            wr_pres  = req_bit;
                            wr_dirty = 1'b1;
                            wr_state = BLK_WAIT_DONE;
                            wr_pend  = req_node;
                        end
                        default: nxt_op = RSP_NACK;
                    endcase
                end
                BLK_WAIT_REV: begin
                    if (op == OP_REVISE && req_node == owner_id) begin
                        wr_en     = 1'b1;
                        mem_we    = 1'b1;
                        wr_dirty  = 1'b0;
                        wr_pres   = cur_pres | pend_bit;
                        wr_state  = BLK_IDLE;
                        nxt_valid = 1'b0;
                    end
                end
                BLK_WAIT_DONE: begin
                    if (op == OP_DONE && req_node == cur_pend) begin
                        wr_en     = 1'b1;
                        wr_state  = BLK_IDLE;
                        nxt_valid = 1'b0;
                    end
                end
                default: nxt_op = RSP_NACK;
            endcase
        end
    end

endmodule

// File: rtl/dir_reply_reg.sv
module dir_reply_reg
    import dir_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int DATA_W = 32,
    parameter int NODE_W = $clog2(NODES),
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              nxt_valid,
    input  rsp_op_t           nxt_op,
    input  logic [NODE_W-1:0] nxt_dest,
    input  logic [BLK_W-1:0]  nxt_blk,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic [NODES-1:0]  nxt_vec,
    input  logic [NODE_W-1:0] nxt_owner,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic [NODE_W-1:0] rsp_dest,
    output logic [BLK_W-1:0]  rsp_blk,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NODES-1:0]  rsp_vec,
    output logic [NODE_W-1:0] rsp_owner
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_op    <= '0;
            rsp_dest  <= '0;
            rsp_blk   <= '0;
            rsp_data  <= '0;
            rsp_vec   <= '0;
            rsp_owner <= '0;
        end else begin
            rsp_valid <= nxt_valid;
            if (nxt_valid) begin
                rsp_op    <= nxt_op;
                rsp_dest  <= nxt_dest;
                rsp_blk   <= nxt_blk;
                rsp_data  <= nxt_data;
                rsp_vec   <= nxt_vec;
                rsp_owner <= nxt_owner;
            end
        end
    end

    // R10: every reply follows an accepted request by one cycle
    assert_reply_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(fire));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 16,
    parameter int BLOCKS = 64,
    parameter int DATA_W = 32,
    parameter int NODE_W = $clog2(NODES),
    parameter int BLK_W  = $clog2(BLOCKS),
    parameter logic [DATA_W-1:0] INIT_BASE = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [NODE_W-1:0] req_node,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic [NODE_W-1:0] rsp_dest,
    output logic [BLK_W-1:0]  rsp_blk,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NODES-1:0]  rsp_vec,
    output logic [NODE_W-1:0] rsp_owner
);

    logic              ready_q;
    logic              fire;
    blk_state_t        cur_state;
    logic              cur_dirty;
    logic [NODES-1:0]  cur_pres;
    logic [NODE_W-1:0] cur_pend;
    logic [DATA_W-1:0] cur_data;
    logic              wr_en;
    blk_state_t        wr_state;
    logic              wr_dirty;
    logic [NODES-1:0]  wr_pres;
    logic [NODE_W-1:0] wr_pend;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic              nxt_valid;
    rsp_op_t           nxt_op;
    logic [DATA_W-1:0] nxt_data;
    logic [NODES-1:0]  nxt_vec;
    logic [NODE_W-1:0] nxt_owner;

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign fire      = req_valid && ready_q;

    dir_entry_store #(
        .NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W),
        .NODE_W(NODE_W), .BLK_W(BLK_W), .INIT_BASE(INIT_BASE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .idx(req_blk),
        .cur_state(cur_state), .cur_dirty(cur_dirty), .cur_pres(cur_pres),
        .cur_pend(cur_pend), .cur_data(cur_data),
        .wr_en(wr_en), .wr_state(wr_state), .wr_dirty(wr_dirty),
        .wr_pres(wr_pres), .wr_pend(wr_pend),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dir_txn_fsm #(
        .NODES(NODES), .DATA_W(DATA_W), .NODE_W(NODE_W)
    ) u_fsm (
        .fire(fire), .req_op(req_op), .req_node(req_node), .req_data(req_data),
        .cur_state(cur_state), .cur_dirty(cur_dirty), .cur_pres(cur_pres),
        .cur_pend(cur_pend), .cur_data(cur_data),
        .wr_en(wr_en), .wr_state(wr_state), .wr_dirty(wr_dirty),
        .wr_pres(wr_pres), .wr_pend(wr_pend),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .nxt_valid(nxt_valid), .nxt_op(nxt_op), .nxt_data(nxt_data),
        .nxt_vec(nxt_vec), .nxt_owner(nxt_owner)
    );

    dir_reply_reg #(
        .NODES(NODES), .DATA_W(DATA_W), .NODE_W(NODE_W), .BLK_W(BLK_W)
    ) u_reply (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .nxt_valid(nxt_valid), .nxt_op(nxt_op), .nxt_dest(req_node),
        .nxt_blk(req_blk), .nxt_data(nxt_data), .nxt_vec(nxt_vec),
        .nxt_owner(nxt_owner),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_dest(rsp_dest),
        .rsp_blk(rsp_blk), .rsp_data(rsp_data), .rsp_vec(rsp_vec),
        .rsp_owner(rsp_owner)
    );

    // R4/R8: a message that closes a transaction is answered by silence
    assert_silent_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (req_op == 2'd2 || req_op == 2'd3)) |=> (!rsp_valid || rsp_op == 2'd2));

    // R1: ready is held low only during reset
    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> req_ready);

endmodule

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;

    localparam int NODES  = 16;
    localparam int DATA_W = 32;
    localparam logic [31:0] BASE = 32'hC0DE_0000;
    localparam logic [1:0] RD = 2'd0, RX = 2'd1, RV = 2'd2, DN = 2'd3;
    localparam logic [1:0] K_DATA = 2'd0, K_OWN = 2'd1, K_NACK = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_node = '0;
    logic [5:0]  req_blk = '0;
    logic [31:0] req_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_op;
    logic [3:0]  rsp_dest;
    logic [5:0]  rsp_blk;
    logic [31:0] rsp_data;
    logic [15:0] rsp_vec;
    logic [3:0]  rsp_owner;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_dest(rsp_dest), .rsp_blk(rsp_blk),
        .rsp_data(rsp_data), .rsp_vec(rsp_vec), .rsp_owner(rsp_owner)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [3:0] node, input logic [5:0] blk, input logic [31:0] d);
        req_valid = 1'b1; req_op = op; req_node = node; req_blk = blk; req_data = d;
    endtask

    // one request, reply sampled at the following negedge
    task automatic send(input logic [1:0] op, input logic [3:0] node, input logic [5:0] blk, input logic [31:0] d);
        @(negedge clk);
        drive(op, node, blk, d);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_data(input string req, input logic [3:0] node, input logic [31:0] d, input logic [15:0] v);
        chk(rsp_valid && rsp_op == K_DATA && rsp_dest == node, req, {rsp_valid, rsp_op, rsp_dest}, {1'b1, K_DATA, node});
        chk(rsp_data == d, req, rsp_data, d);
        chk(rsp_vec == v, req, {16'h0, rsp_vec}, {16'h0, v});
    endtask

    task automatic expect_owner(input string req, input logic [3:0] own);
        chk(rsp_valid && rsp_op == K_OWN && rsp_owner == own, req, {rsp_valid, rsp_op, rsp_owner}, {1'b1, K_OWN, own});
    endtask

    task automatic expect_nack(input string req);
        chk(rsp_valid && rsp_op == K_NACK, req, {rsp_valid, rsp_op}, {1'b1, K_NACK});
    endtask

    task automatic expect_silent(input string req);
        chk(!rsp_valid, req, {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!rsp_valid, "R1 no reply after reset", {31'h0, rsp_valid}, 0);
        chk(req_ready, "R1 ready after reset", {31'h0, req_ready}, 1);
        send(RD, 4'd2, 6'd5, 0);
        expect_data("R1 R2 clean read of init word", 4'd2, BASE + 5, 16'h0);
    endtask

    task automatic t_sharers_and_excl;
        send(RD, 4'd3, 6'd5, 0);
        expect_data("R2 second reader", 4'd3, BASE + 5, 16'h0);
        send(RD, 4'd7, 6'd5, 0);
        expect_data("R2 third reader", 4'd7, BASE + 5, 16'h0);
        send(RX, 4'd9, 6'd5, 0);
        expect_data("R5 exclusive on clean block lists sharers", 4'd9, BASE + 5, 16'h008C);
    endtask

    task automatic t_busy_done;
        send(RD, 4'd1, 6'd5, 0);
        expect_nack("R7 read during completion wait");
        send(DN, 4'd4, 6'd5, 0);
        expect_nack("R7 completion from wrong node");
        send(RD, 4'd8, 6'd40, 0);
        expect_data("R10 other block served while one waits", 4'd8, BASE + 40, 16'h0);
        send(DN, 4'd9, 6'd5, 0);
        expect_silent("R8 completion closes silently");
    endtask

    task automatic t_dirty_read;
        send(RD, 4'd1, 6'd5, 0);
        expect_owner("R3 read of dirty block names owner", 4'd9);
        send(RV, 4'd4, 6'd5, 32'h1111_2222);
        expect_nack("R7 revision from wrong node");
        send(RV, 4'd9, 6'd5, 32'hDEAD_BEEF);
        expect_silent("R4 revision closes silently");
        send(RD, 4'd6, 6'd5, 0);
        expect_data("R4 memory refreshed, block clean", 4'd6, 32'hDEAD_BEEF, 16'h0);
        send(RX, 4'd11, 6'd5, 0);
        expect_data("R4 owner and reader kept as sharers", 4'd11, 32'hDEAD_BEEF, 16'h0242);
        send(DN, 4'd11, 6'd5, 0);
        expect_silent("R8 completion");
    endtask

    task automatic t_dirty_excl;
        send(RX, 4'd12, 6'd5, 0);
        expect_owner("R6 exclusive on dirty block names owner", 4'd11);
        send(DN, 4'd12, 6'd5, 0);
        expect_silent("R8 completion after R6");
        send(RD, 4'd0, 6'd5, 0);
        expect_owner("R6 ownership passed to requester", 4'd12);
        send(RV, 4'd12, 6'd5, 32'h0BAD_F00D);
        expect_silent("R4 second revision");
        send(RD, 4'd0, 6'd5, 0);
        expect_data("R4 second write-back visible", 4'd0, 32'h0BAD_F00D, 16'h0);
    endtask

    task automatic t_stray;
        send(RV, 4'd3, 6'd20, 32'h5555_5555);
        expect_nack("R9 revision to idle block");
        send(DN, 4'd3, 6'd21, 0);
        expect_nack("R9 completion to idle block");
        send(RX, 4'd3, 6'd20, 0);
        expect_data("R9 memory and sharers untouched", 4'd3, BASE + 20, 16'h0);
        send(DN, 4'd3, 6'd20, 0);
        expect_silent("R8 completion");
        send(RX, 4'd2, 6'd21, 0);
        expect_data("R9 idle block still clean", 4'd2, BASE + 21, 16'h0);
        send(DN, 4'd2, 6'd21, 0);
        expect_silent("R8 completion");
    endtask

    task automatic t_pipeline;
        @(negedge clk);
        drive(RD, 4'd1, 6'd30, 0);
        @(negedge clk);
        drive(RD, 4'd2, 6'd31, 0);
        expect_data("R10 first of burst", 4'd1, BASE + 30, 16'h0);
        chk(rsp_blk == 6'd30, "R10 first reply block", {26'h0, rsp_blk}, 30);
        @(negedge clk);
        drive(RX, 4'd4, 6'd30, 0);
        expect_data("R10 second of burst", 4'd2, BASE + 31, 16'h0);
        chk(rsp_blk == 6'd31, "R10 second reply block", {26'h0, rsp_blk}, 31);
        @(negedge clk);
        req_valid = 1'b0;
        expect_data("R10 third of burst sees first reader", 4'd4, BASE + 30, 16'h0002);
        @(negedge clk);
        expect_silent("R10 no reply without request");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!req_ready, "R1 not ready in reset", {31'h0, req_ready}, 0);
        rst_n = 1'b1;
        t_reset();
        t_sharers_and_excl();
        t_busy_done();
        t_dirty_read();
        t_dirty_excl();
        t_stray();
        t_pipeline();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule